// File: doc/BRIEF.md
# Peripheral DMA Transfer Channel

This block moves data in one direction between a serial peripheral and system memory, so the processor does not have to. Software sets a memory address pointer, a transfer count and an interrupt enable through a small write port. After that, every data-ready pulse from the peripheral produces exactly one memory access. When memory accepts the access, the pointer steps by the transfer size and the count drops by one.

A build parameter selects the direction. In the receive variant, the word the peripheral captured is written to memory. In the transmit variant, a word is read from memory and handed to the peripheral's transmit holding register together with a one-cycle load strobe. A peripheral is served by two instances, one of each direction. While the count is zero the channel is idle. The end-of-transfer interrupt is a level that stays high for as long as the count is zero and the interrupt is enabled.

Top module: `pdma_chan`

## Requirements
- R1: After reset the pointer, the count and the interrupt enable are zero, and mem_valid, eot_irq and per_tx_load are low.
- R2: A configuration write with cfg_sel 0 loads the pointer from cfg_wdata. With cfg_sel 1 it loads the count from the low CNT_W bits. With cfg_sel 2 it loads the interrupt enable from bit 0.
- R3: The channel is idle with a nonzero count. If per_req is high at a clock edge, mem_valid is high from the next cycle. mem_addr equals the pointer and mem_size equals per_wide (0 = one byte, 1 = DATA_W/8 bytes). The receive variant drives mem_we high and mem_wdata with the captured per_rx_data, with the bits above the low byte cleared when the transfer is narrow. The transmit variant drives mem_we low.
- R4: While mem_valid is high and mem_ready is low, mem_valid, mem_addr, mem_size and mem_we stay unchanged.
- R5: On the cycle an access is accepted (mem_valid and mem_ready both high), the pointer becomes mem_addr plus 1 or DATA_W/8, depending on mem_size. The count decreases by one.
- R6: While the count is zero, per_req is ignored: no access starts, and the pointer and count keep their values. Writing a nonzero count arms the channel again.
- R7: A per_req that arrives while an access is outstanding, including on its accept cycle, is ignored. Each accepted request gives exactly one access.
- R8: eot_irq is high exactly when the count is zero and the interrupt enable is set.
- R9: In the transmit variant, the cycle after an accept drives per_tx_data with mem_rdata (upper bits cleared for a narrow transfer) and drives per_tx_load high for exactly one cycle.
- R10: A configuration write to the pointer or the count in the same cycle as an accept takes priority over the automatic update.
- R11: If the count is written to zero while an access is outstanding, the access still completes, and the count stays at zero (no wrap).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 pointer, 1 count, 2 control |
| cfg_wdata | input | ADDR_W | Configuration write data |
| per_req | input | 1 | Peripheral data-ready request |
| per_wide | input | 1 | Transfer size of this request: 0 byte, 1 full word |
| per_rx_data | input | DATA_W | Received word (receive variant) |
| per_tx_data | output | DATA_W | Word for the transmit holding register |
| per_tx_load | output | 1 | One-cycle load strobe for per_tx_data |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access |
| mem_we | output | 1 | 1 write, 0 read |
| mem_size | output | 1 | 0 byte, 1 full word |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid while mem_ready is high |
| ptr_q | output | ADDR_W | Current address pointer |
| cnt_q | output | CNT_W | Current remaining count |
| eot_irq | output | 1 | End-of-transfer interrupt level |

## Verification
The assertions check the following on every cycle:
- the memory request stays stable while it waits for mem_ready;
- no access starts while the count is zero;
- the pointer steps by the size of the access and the count decrements on each accept, unless software writes in that cycle;
- the interrupt stays low while the count is nonzero;
- in the transmit variant, the load strobe pairs one to one with accepts.

Some behaviours only the directed scenarios can show:
- that the data actually reaches memory or the transmit register with the correct byte masking;
- that requests arriving during a wait are dropped;
- that software writes win over the automatic update;
- that a count cleared mid-access stays at zero.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
   typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} pdma_dir_e;

   localparam logic [1:0] SEL_PTR  = 2'd0;
   localparam logic [1:0] SEL_CNT  = 2'd1;
   localparam logic [1:0] SEL_CTRL = 2'd2;
endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
   import pdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              acc,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [ADDR_W-1:0] acc_step,
   output logic [ADDR_W-1:0] ptr_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              irq_en_o
);
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic wr_ptr, wr_cnt, wr_ctrl;
   assign wr_ptr  = cfg_we && (cfg_sel == SEL_PTR);
   assign wr_cnt  = cfg_we && (cfg_sel == SEL_CNT);
   assign wr_ctrl = cfg_we && (cfg_sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_o    <= '0;
         cnt_o    <= '0;
         irq_en_o <= 1'b0;
      end else begin
         if (wr_ptr)
            ptr_o <= cfg_wdata;
         else if (acc)
            ptr_o <= acc_addr + acc_step;

         if (wr_cnt)
            cnt_o <= cfg_wdata[CNT_W-1:0];
         else if (acc && (cnt_o != '0))
            cnt_o <= cnt_o - CNT_ONE;

         if (wr_ctrl)
            irq_en_o <= cfg_wdata[0];
      end
   end
endmodule

// File: rtl/pdma_req.sv
module pdma_req #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              per_req,
   input  logic              per_wide,
   input  logic [DATA_W-1:0] per_rx_data,
   input  logic              armed,
   input  logic [ADDR_W-1:0] ptr,
   input  logic              mem_ready,
   output logic              busy,
   output logic [ADDR_W-1:0] lat_addr,
   output logic              lat_wide,
   output logic [DATA_W-1:0] lat_data,
   output logic              acc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         lat_addr <= '0;
         lat_wide <= 1'b0;
         lat_data <= '0;
      end else if (busy) begin
         if (mem_ready)
            busy <= 1'b0;
      end else if (per_req && armed) begin
         busy     <= 1'b1;
         lat_addr <= ptr;
         lat_wide <= per_wide;
         lat_data <= per_rx_data;
      end
   end

   assign acc = busy && mem_ready;
endmodule

// File: rtl/pdma_dside.sv
module pdma_dside
   import pdma_pkg::*;
#(
   parameter pdma_dir_e DIR    = DIR_RX,
   parameter int        DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              lat_wide,
   input  logic [DATA_W-1:0] lat_data,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] per_tx_data,
   output logic              per_tx_load
);
   function automatic logic [DATA_W-1:0] fit(input logic wide, input logic [DATA_W-1:0] d);
      return wide ? d : {{(DATA_W-8){1'b0}}, d[7:0]};
   endfunction

   generate
      if (DIR == DIR_RX) begin : g_rx
         logic unused_rx_side;
         assign unused_rx_side = ^{mem_rdata, clk, rst_n, acc};
         assign mem_we      = 1'b1;
         assign mem_wdata   = fit(lat_wide, lat_data);
         assign per_tx_data = '0;
         assign per_tx_load = 1'b0;
      end else begin : g_tx
         logic              load_q;
         logic [DATA_W-1:0] hold_q;
         logic              unused_tx_side;
         assign unused_tx_side = ^lat_data;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               load_q <= 1'b0;
               hold_q <= '0;
            end else begin
               load_q <= acc;
               if (acc)
                  hold_q <= fit(lat_wide, mem_rdata);
            end
         end
         assign mem_we      = 1'b0;
         assign mem_wdata   = '0;
         assign per_tx_data = hold_q;
         assign per_tx_load = load_q;
      end
   endgenerate
endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
   import pdma_pkg::*;
#(
   parameter pdma_dir_e DIR    = DIR_RX,
   parameter int        ADDR_W = 32,
   parameter int        CNT_W  = 16,
   parameter int        DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              per_req,
   input  logic              per_wide,
   input  logic [DATA_W-1:0] per_rx_data,
   output logic [DATA_W-1:0] per_tx_data,
   output logic              per_tx_load,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic              mem_we,
   output logic              mem_size,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] ptr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              eot_irq
);
   localparam int WIDE_BYTES = DATA_W / 8;
   localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(WIDE_BYTES);
   localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(1);

   generate
      if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_data
         $error("pdma_chan: DATA_W must be a multiple of 8 and at least 16");
      end
      if (CNT_W < 1 || CNT_W > ADDR_W) begin : g_bad_cnt
         $error("pdma_chan: CNT_W must lie in 1..ADDR_W");
      end
   endgenerate

   logic              irq_en;
   logic              busy, acc, lat_wide;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_data;

   pdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .acc      (acc),
      .acc_addr (lat_addr),
      .acc_step (lat_wide ? STEP_WIDE : STEP_NARROW),
      .ptr_o    (ptr_q),
      .cnt_o    (cnt_q),
      .irq_en_o (irq_en)
   );

   pdma_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .per_req    (per_req),
      .per_wide   (per_wide),
      .per_rx_data(per_rx_data),
      .armed      (cnt_q != '0),
      .ptr        (ptr_q),
      .mem_ready  (mem_ready),
      .busy       (busy),
      .lat_addr   (lat_addr),
      .lat_wide   (lat_wide),
      .lat_data   (lat_data),
      .acc        (acc)
   );

   pdma_dside #(.DIR(DIR), .DATA_W(DATA_W)) u_dside (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc        (acc),
      .lat_wide   (lat_wide),
      .lat_data   (lat_data),
      .mem_rdata  (mem_rdata),
      .mem_we     (mem_we),
      .mem_wdata  (mem_wdata),
      .per_tx_data(per_tx_data),
      .per_tx_load(per_tx_load)
   );

   assign mem_valid = busy;
   assign mem_addr  = lat_addr;
   assign mem_size  = lat_wide;
   assign eot_irq   = irq_en && (cnt_q == '0);
endmodule

// File: rtl/pdma_chan_chk.sv
module pdma_chan_chk
   import pdma_pkg::*;
#(
   parameter pdma_dir_e DIR    = DIR_RX,
   parameter int        ADDR_W = 32,
   parameter int        CNT_W  = 16,
   parameter int        DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic              mem_we,
   input logic              mem_size,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] ptr_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              irq_en,
   input logic              eot_irq,
   input logic              per_tx_load
);
   localparam logic [ADDR_W-1:0] S_WIDE   = ADDR_W'(DATA_W / 8);
   localparam logic [ADDR_W-1:0] S_NARROW = ADDR_W'(1);
   localparam logic [CNT_W-1:0]  C_ONE    = {{(CNT_W-1){1'b0}}, 1'b1};

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_size) && $stable(mem_we)));

   assert_idle_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_valid && cnt_q == '0) |=> !mem_valid);

   assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready && !cfg_we) |=>
         (ptr_q == $past(mem_addr) + ($past(mem_size) ? S_WIDE : S_NARROW)));

   assert_cnt_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready && !cfg_we && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - C_ONE));

   assert_no_irq_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> !eot_irq);

   assert_irq_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready && !cfg_we && irq_en && cnt_q == C_ONE) |=> eot_irq);

   generate
      if (DIR == DIR_TX) begin : g_tx_chk
         assert_load_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_valid && mem_ready) |=> per_tx_load);
         assert_load_only_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
            per_tx_load |-> $past(mem_valid && mem_ready));
      end
   endgenerate
endmodule

bind pdma_chan pdma_chan_chk #(.DIR(DIR), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .mem_valid  (mem_valid),
   .mem_ready  (mem_ready),
   .mem_we     (mem_we),
   .mem_size   (mem_size),
   .mem_addr   (mem_addr),
   .ptr_q      (ptr_q),
   .cnt_q      (cnt_q),
   .irq_en     (irq_en),
   .eot_irq    (eot_irq),
   .per_tx_load(per_tx_load)
);

// File: tb/pdma_chan_tb.sv
module pdma_chan_tb;
   import pdma_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // receive instance
   logic        r_we = 0;  logic [1:0]  r_sel = 0;  logic [31:0] r_wd = 0;
   logic        r_req = 0, r_wide = 0;  logic [15:0] r_rx = 0;
   logic [15:0] r_txd;  logic r_txl;
   logic        r_mv, r_rdy = 0, r_mwe, r_msz;
   logic [31:0] r_ma;  logic [15:0] r_mwd;
   logic [31:0] r_ptr; logic [15:0] r_cnt; logic r_irq;

   // transmit instance
   logic        t_we = 0;  logic [1:0]  t_sel = 0;  logic [31:0] t_wd = 0;
   logic        t_req = 0, t_wide = 0;
   logic [15:0] t_txd;  logic t_txl;
   logic        t_mv, t_rdy = 0, t_mwe, t_msz;
   logic [31:0] t_ma;  logic [15:0] t_mwd, t_rd = 0;
   logic [31:0] t_ptr; logic [15:0] t_cnt; logic t_irq;

   pdma_chan #(.DIR(DIR_RX)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(r_we), .cfg_sel(r_sel), .cfg_wdata(r_wd),
      .per_req(r_req), .per_wide(r_wide), .per_rx_data(r_rx),
      .per_tx_data(r_txd), .per_tx_load(r_txl),
      .mem_valid(r_mv), .mem_ready(r_rdy), .mem_we(r_mwe), .mem_size(r_msz),
      .mem_addr(r_ma), .mem_wdata(r_mwd), .mem_rdata(16'h0),
      .ptr_q(r_ptr), .cnt_q(r_cnt), .eot_irq(r_irq));

   pdma_chan #(.DIR(DIR_TX)) u_dut_tx (
      .clk(clk), .rst_n(rst_n), .cfg_we(t_we), .cfg_sel(t_sel), .cfg_wdata(t_wd),
      .per_req(t_req), .per_wide(t_wide), .per_rx_data(16'h0),
      .per_tx_data(t_txd), .per_tx_load(t_txl),
      .mem_valid(t_mv), .mem_ready(t_rdy), .mem_we(t_mwe), .mem_size(t_msz),
      .mem_addr(t_ma), .mem_wdata(t_mwd), .mem_rdata(t_rd),
      .ptr_q(t_ptr), .cnt_q(t_cnt), .eot_irq(t_irq));

   // {wide, data, wait cycles}
   localparam logic [20:0] VEC [6] = '{
      {1'b0, 16'h00A5, 4'd0}, {1'b1, 16'h1234, 4'd2}, {1'b1, 16'hBEEF, 4'd0},
      {1'b0, 16'hFF3C, 4'd3}, {1'b1, 16'h8001, 4'd1}, {1'b0, 16'h0177, 4'd0}};

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic rcfg(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk); r_we = 1; r_sel = s; r_wd = d;
      @(negedge clk); r_we = 0;
   endtask

   task automatic tcfg(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk); t_we = 1; t_sel = s; t_wd = d;
      @(negedge clk); t_we = 0;
   endtask

   logic [31:0] ep;
   logic [15:0] ec;

   task automatic rx_xfer(input logic w, input logic [15:0] d, input int dly, input bit poke);
      logic [15:0] ed;
      ed = w ? d : {8'h00, d[7:0]};
      @(negedge clk); r_req = 1; r_wide = w; r_rx = d;
      @(negedge clk); r_req = 0;
      chk(r_mv && r_mwe, "R3 rx request", {r_mv, r_mwe}, 2'b11);
      chk(r_ma == ep, "R3 rx address", r_ma, ep);
      chk(r_msz == w, "R3 rx size", r_msz, w);
      chk(r_mwd == ed, "R3 rx write data", r_mwd, ed);
      for (int i = 0; i < dly; i++) begin
         r_req = poke;
         @(negedge clk);
         chk(r_mv && r_ma == ep, "R4 rx hold", r_ma, ep);
      end
      r_req = 0; r_rdy = 1;
      @(negedge clk); r_rdy = 0;
      ep = ep + (w ? 32'd2 : 32'd1);
      ec = ec - 16'd1;
      chk(r_ptr == ep, "R5 rx pointer", r_ptr, ep);
      chk(r_cnt == ec, "R5 rx count", r_cnt, ec);
      chk(!r_mv, "R7 single access per request", r_mv, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(r_ptr == 0 && r_cnt == 0, "R1 reset regs", {r_ptr, r_cnt}, 0);
      chk(!r_mv && !r_irq && !t_txl && !t_mv, "R1 reset outputs", {r_mv, r_irq, t_txl, t_mv}, 0);

      // R2 configuration
      rcfg(2'd0, 32'h0000_1000);
      rcfg(2'd1, 32'hABCD_0006);
      chk(r_ptr == 32'h0000_1000, "R2 pointer load", r_ptr, 32'h1000);
      chk(r_cnt == 16'd6, "R2 count load low bits", r_cnt, 6);
      chk(!r_irq, "R8 irq low with count", r_irq, 0);
      rcfg(2'd2, 32'h1);

      // table walk: R3 R4 R5 R7
      ep = 32'h0000_1000; ec = 16'd6;
      foreach (VEC[k]) rx_xfer(VEC[k][20], VEC[k][19:4], int'(VEC[k][3:0]), VEC[k][3:0] != 0);
      chk(r_irq, "R8 irq at zero count", r_irq, 1);
      rcfg(2'd2, 32'h0);
      chk(!r_irq, "R8 irq masked", r_irq, 0);
      rcfg(2'd2, 32'h1);

      // R6 request with zero count ignored
      @(negedge clk); r_req = 1; r_wide = 1;
      @(negedge clk); r_req = 0;
      chk(!r_mv, "R6 no access at zero", r_mv, 0);
      chk(r_ptr == ep && r_cnt == 0, "R6 state kept", r_ptr, ep);
      rcfg(2'd1, 32'd5); ec = 16'd5;
      chk(!r_irq, "R8 irq cleared on rearm", r_irq, 0);
      rx_xfer(1'b0, 16'h5A5A, 0, 0);

      // R10 count write on accept cycle wins
      @(negedge clk); r_req = 1; r_wide = 1; r_rx = 16'h1111;
      @(negedge clk); r_req = 0; r_rdy = 1; r_we = 1; r_sel = 2'd1; r_wd = 32'd9;
      @(negedge clk); r_rdy = 0; r_we = 0;
      ep = ep + 32'd2;
      chk(r_cnt == 16'd9, "R10 count write wins", r_cnt, 9);
      chk(r_ptr == ep, "R10 pointer still steps", r_ptr, ep);

      // R11 count cleared while access pending
      @(negedge clk); r_req = 1; r_wide = 0;
      @(negedge clk); r_req = 0; r_we = 1; r_sel = 2'd1; r_wd = 32'd0;
      @(negedge clk); r_we = 0;
      chk(r_mv, "R11 access still pending", r_mv, 1);
      r_rdy = 1;
      @(negedge clk); r_rdy = 0;
      chk(r_cnt == 16'd0, "R11 count stays zero", r_cnt, 0);
      chk(r_irq, "R11 irq at zero", r_irq, 1);

      // R9 transmit path
      tcfg(2'd0, 32'h0000_2000);
      tcfg(2'd1, 32'd2);
      @(negedge clk); t_req = 1; t_wide = 1;
      @(negedge clk); t_req = 0;
      chk(t_mv && !t_mwe && t_ma == 32'h2000, "R3 tx read request", {t_mv, t_mwe, t_ma}, {2'b10, 32'h2000});
      t_rdy = 1; t_rd = 16'hC3D4;
      @(negedge clk); t_rdy = 0; t_rd = 16'h0;
      chk(t_txl && t_txd == 16'hC3D4, "R9 tx wide load", t_txd, 16'hC3D4);
      @(negedge clk);
      chk(!t_txl, "R9 tx load one cycle", t_txl, 0);
      @(negedge clk); t_req = 1; t_wide = 0;
      @(negedge clk); t_req = 0;
      chk(t_ma == 32'h2002 && !t_msz, "R5 tx pointer step", t_ma, 32'h2002);
      t_rdy = 1; t_rd = 16'h9E7F;
      @(negedge clk); t_rdy = 0;
      chk(t_txl && t_txd == 16'h007F, "R9 tx narrow load", t_txd, 16'h007F);
      chk(t_cnt == 0 && t_ptr == 32'h2003, "R5 tx final state", {t_cnt, t_ptr}, {16'h0, 32'h2003});

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule